// File: doc/BRIEF.md
# Signaling Time-Slot Output Serializer

This block turns the signaling recovered by a T1 or E1 receive framer into a serial time-division stream. The stream runs at 2.048 Mbit/s and carries 32 channels of eight bits in each 125 µs frame. A clock enable marks each bit period. A frame-start pulse fixes where the frame begins, and a free-running position counter tracks the bit within the frame. Alongside the data bit the block drives a per-bit drive enable, which stands in for a tri-state pad. Channels and bits that carry nothing are left floating.

Four modes are supported.

- **Channel-associated modes:** each channel carries a four-bit signaling nibble in its low half.
- **Common-channel modes:** a per-timeslot routing table places whole received timeslot bytes into chosen output channels, so an external multi-channel link controller can pick them up.

Two write ports load the data that feeds the stream:

- one for nibbles, indexed by channel;
- one for received bytes, indexed by timeslot.

Both are double-buffered, and the buffered copy is taken at frame start. One frame's output therefore never mixes old and new data. A global enable forces the whole output to float.

Top module: `sig_tdm_serializer`

## Requirements
- R1: A clock edge with `bit_en` and `frame_start` both high sets the frame position to 0, which is channel 0, bit 7. Each later `bit_en` advances the position by one, and it wraps from 255 to 0. With `bit_en` low the position holds. Channel = position/8, and bits go out most significant first.
- R2: With `mode` = 2'b00 (T1, per-channel signaling), channels 0 to 23 drive bits 3..0 with the buffered nibble of that channel (A = bit 3, D = bit 0). Bits 7..4 of every channel and all of channels 24 to 31 are undriven.
- R3: With `mode` = 2'b10 (E1, per-channel signaling), all 32 channels drive bits 3..0 with their own buffered nibble, and bits 7..4 are undriven.
- R4: With `mode` = 2'b01 (T1, common channel), each timeslot has a routing entry: bit 5 is valid and bits 4..0 are the output channel. A valid entry whose channel is below 24 puts the full buffered byte of that timeslot in that channel. Entries pointing at channel 24 or above are ignored.
- R5: With `mode` = 2'b11 (E1, common channel), only the entries of timeslots 15, 16 and 31 are used, and each may target any of the 32 channels. Entries of all other timeslots have no effect.
- R6: In both common-channel modes, a channel that no usable entry targets is undriven. When several usable entries target the same channel, the lowest-numbered timeslot supplies the byte.
- R7: With `out_en` low, `ser_oe` is low on every bit.
- R8: Written nibbles and bytes reach the output only from the next frame start after the write. A write in the same cycle as a frame start is not captured by that frame start.
- R9: `ser_data` is 0 whenever `ser_oe` is 0.
- R10: Reset clears the frame position, all nibble and byte buffers and all routing entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One pulse per 2.048 Mbit/s bit period |
| frame_start | input | 1 | Frame alignment, taken when `bit_en` is high |
| mode | input | 2 | 00 T1 nibble, 01 T1 routed, 10 E1 nibble, 11 E1 routed |
| out_en | input | 1 | Global output enable |
| nib_we | input | 1 | Nibble write strobe |
| nib_addr | input | 5 | Channel of nibble write |
| nib_data | input | 4 | Signaling nibble ABCD |
| byte_we | input | 1 | Timeslot byte write strobe |
| byte_addr | input | 5 | Timeslot of byte write |
| byte_data | input | 8 | Received timeslot byte |
| map_we | input | 1 | Routing entry write strobe |
| map_addr | input | 5 | Timeslot whose entry is written |
| map_data | input | 6 | Bit 5 valid, bits 4..0 output channel |
| ser_data | output | 1 | Serial output bit |
| ser_oe | output | 1 | Drive enable for `ser_data` |

## Verification
A data write can land in the same cycle as a frame start, and the two must not merge. The bench forces this by raising `frame_start` and a nibble write on one edge. Its behavioural model copies the buffer before applying the write, so the old value is expected for the whole of the next frame and the new one only after the following frame start. Routing conflicts and bit-enable gaps are mixed into the same run, and every clock is compared against the model.

// File: rtl/sig_tdm_pkg.sv
package sig_tdm_pkg;
  localparam int NUM_CH = 32;
  localparam int CH_BITS = 8;
  localparam int NIB_W = 4;
  localparam int T1_CH = 24;
  localparam int SLOT_W = $clog2(NUM_CH);
  localparam int BIT_W = $clog2(CH_BITS);
  localparam int POS_W = SLOT_W + BIT_W;

  typedef enum logic [1:0] {
    MODE_T1_CAS = 2'b00,
    MODE_T1_CCS = 2'b01,
    MODE_E1_CAS = 2'b10,
    MODE_E1_CCS = 2'b11
  } sig_mode_e;

  // channel number carried by a frame position
  function automatic logic [SLOT_W-1:0] slot_of(input logic [POS_W-1:0] pos);
    return pos[POS_W-1:BIT_W];
  endfunction

  // bit index inside the channel, MSB sent first
  function automatic logic [BIT_W-1:0] bit_of(input logic [POS_W-1:0] pos);
    return ~pos[BIT_W-1:0];
  endfunction

  // E1 routed mode accepts only these source timeslots
  function automatic logic e1_route_src(input logic [SLOT_W-1:0] ts);
    return (ts == SLOT_W'(15)) || (ts == SLOT_W'(16)) || (ts == SLOT_W'(31));
  endfunction
endpackage

// File: rtl/sig_bit_timer.sv
module sig_bit_timer
  import sig_tdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             frame_start,
  output logic [POS_W-1:0] pos,
  output logic             frame_load
);
  assign frame_load = bit_en & frame_start;

  always_ff @(posedge clk) begin
    if (!rst_n)          pos <= '0;
    else if (frame_load) pos <= '0;
    else if (bit_en)     pos <= pos + POS_W'(1);
  end
endmodule

// File: rtl/sig_frame_store.sv
module sig_frame_store
  import sig_tdm_pkg::*;
#(
  parameter int DEPTH = NUM_CH,
  parameter int DW    = NIB_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [DW-1:0]              wdata,
  input  logic                       load,
  output logic [DEPTH-1:0][DW-1:0]   shadow
);
  logic [DEPTH-1:0][DW-1:0] live;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live[i]   <= '0;
        shadow[i] <= '0;
      end else begin
        if (load) shadow[i] <= live[i];
        if (we && waddr == AW'(i)) live[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/sig_ccs_router.sv
module sig_ccs_router
  import sig_tdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  sig_mode_e         mode,
  input  logic              map_we,
  input  logic [SLOT_W-1:0] map_addr,
  input  logic [SLOT_W:0]   map_data,
  input  logic [SLOT_W-1:0] slot,
  output logic              hit,
  output logic [SLOT_W-1:0] src_ts
);
  logic [NUM_CH-1:0]             map_v;
  logic [NUM_CH-1:0][SLOT_W-1:0] map_c;
  logic [NUM_CH-1:0]             usable;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_map
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        map_v[i] <= 1'b0;
        map_c[i] <= '0;
      end else if (map_we && map_addr == SLOT_W'(i)) begin
        map_v[i] <= map_data[SLOT_W];
        map_c[i] <= map_data[SLOT_W-1:0];
      end
    end

    always_comb begin
      unique case (mode)
        MODE_T1_CCS: usable[i] = map_v[i] && (map_c[i] < SLOT_W'(T1_CH));
        MODE_E1_CCS: usable[i] = map_v[i] && e1_route_src(SLOT_W'(i));
        default:     usable[i] = 1'b0;
      endcase
    end
  end

  // scan downward so the lowest matching timeslot is the last to win
  always_comb begin
    hit    = 1'b0;
    src_ts = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (usable[k] && map_c[k] == slot) begin
        hit    = 1'b1;
        src_ts = SLOT_W'(k);
      end
    end
  end
endmodule

// File: rtl/sig_tdm_serializer.sv
module sig_tdm_serializer
  import sig_tdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              frame_start,
  input  logic [1:0]        mode,
  input  logic              out_en,
  input  logic              nib_we,
  input  logic [SLOT_W-1:0] nib_addr,
  input  logic [NIB_W-1:0]  nib_data,
  input  logic              byte_we,
  input  logic [SLOT_W-1:0] byte_addr,
  input  logic [CH_BITS-1:0] byte_data,
  input  logic              map_we,
  input  logic [SLOT_W-1:0] map_addr,
  input  logic [SLOT_W:0]   map_data,
  output logic              ser_data,
  output logic              ser_oe
);
  sig_mode_e                        mode_e;
  logic [POS_W-1:0]                 pos;
  logic                             frame_load;
  logic [SLOT_W-1:0]                slot;
  logic [BIT_W-1:0]                 bpos;
  logic [NUM_CH-1:0][NIB_W-1:0]     nib_sh;
  logic [NUM_CH-1:0][CH_BITS-1:0]   byte_sh;
  logic                             ccs_hit;
  logic [SLOT_W-1:0]                ccs_ts;
  logic                             drive;
  logic                             bit_val;

  assign mode_e = sig_mode_e'(mode);
  assign slot   = slot_of(pos);
  assign bpos   = bit_of(pos);

  sig_bit_timer u_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .pos(pos), .frame_load(frame_load)
  );

  sig_frame_store #(.DEPTH(NUM_CH), .DW(NIB_W)) u_nib (
    .clk(clk), .rst_n(rst_n), .we(nib_we), .waddr(nib_addr),
    .wdata(nib_data), .load(frame_load), .shadow(nib_sh)
  );

  sig_frame_store #(.DEPTH(NUM_CH), .DW(CH_BITS)) u_byte (
    .clk(clk), .rst_n(rst_n), .we(byte_we), .waddr(byte_addr),
    .wdata(byte_data), .load(frame_load), .shadow(byte_sh)
  );

  sig_ccs_router u_route (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .map_we(map_we),
    .map_addr(map_addr), .map_data(map_data), .slot(slot),
    .hit(ccs_hit), .src_ts(ccs_ts)
  );

  always_comb begin
    drive   = 1'b0;
    bit_val = 1'b0;
    unique case (mode_e)
      MODE_T1_CAS: begin
        drive   = (bpos < BIT_W'(NIB_W)) && (slot < SLOT_W'(T1_CH));
        bit_val = nib_sh[slot][bpos[1:0]];
      end
      MODE_E1_CAS: begin
        drive   = (bpos < BIT_W'(NIB_W));
        bit_val = nib_sh[slot][bpos[1:0]];
      end
      MODE_T1_CCS, MODE_E1_CCS: begin
        drive   = ccs_hit;
        bit_val = byte_sh[ccs_ts][bpos];
      end
      default: begin
        drive   = 1'b0;
        bit_val = 1'b0;
      end
    endcase
  end

  assign ser_oe   = out_en & drive;
  assign ser_data = ser_oe & bit_val;
endmodule

// File: rtl/sig_tdm_chk.sv
module sig_tdm_chk
  import sig_tdm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              frame_start,
  input logic [1:0]        mode,
  input logic              out_en,
  input logic [POS_W-1:0]  pos,
  input logic [SLOT_W-1:0] slot,
  input logic [BIT_W-1:0]  bpos,
  input logic              ccs_hit,
  input logic [SLOT_W-1:0] ccs_ts,
  input logic              ser_oe,
  input logic              ser_data
);
  p_pos_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !frame_start) |=> (pos == $past(pos) + POS_W'(1)));

  p_pos_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && frame_start) |=> (pos == '0));

  p_pos_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(pos));

  p_upper_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[0] && bpos >= BIT_W'(NIB_W)) |-> !ser_oe);

  p_t1_tail_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && slot >= SLOT_W'(T1_CH)) |-> !ser_oe);

  p_e1_sources_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && ser_oe) |->
      (ccs_ts == SLOT_W'(15) || ccs_ts == SLOT_W'(16) || ccs_ts == SLOT_W'(31)));

  p_unmapped_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && !ccs_hit) |-> !ser_oe);

  p_global_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !ser_oe);

  p_quiet_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |-> !ser_data);
endmodule

bind sig_tdm_serializer sig_tdm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
  .mode(mode), .out_en(out_en), .pos(pos), .slot(slot), .bpos(bpos),
  .ccs_hit(ccs_hit), .ccs_ts(ccs_ts), .ser_oe(ser_oe), .ser_data(ser_data)
);

// File: tb/tb_sig_tdm_serializer.sv
module tb_sig_tdm_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b1;
  logic       frame_start = 1'b0;
  logic [1:0] mode = 2'b10;
  logic       out_en = 1'b1;
  logic       nib_we = 1'b0;
  logic [4:0] nib_addr = '0;
  logic [3:0] nib_data = '0;
  logic       byte_we = 1'b0;
  logic [4:0] byte_addr = '0;
  logic [7:0] byte_data = '0;
  logic       map_we = 1'b0;
  logic [4:0] map_addr = '0;
  logic [5:0] map_data = '0;
  logic       ser_data, ser_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit gaps = 0;
  bit done = 0;
  string cur_tag = "R10";

  // behavioural reference state
  int m_pos = 0;
  int live_nib[32], sh_nib[32], live_byte[32], sh_byte[32];
  int rt_valid[32], rt_chan[32];

  always #10 clk = ~clk;

  sig_tdm_serializer dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .mode(mode), .out_en(out_en), .nib_we(nib_we), .nib_addr(nib_addr),
    .nib_data(nib_data), .byte_we(byte_we), .byte_addr(byte_addr),
    .byte_data(byte_data), .map_we(map_we), .map_addr(map_addr),
    .map_data(map_data), .ser_data(ser_data), .ser_oe(ser_oe)
  );

  initial begin
    for (int i = 0; i < 32; i++) begin
      live_nib[i] = 0; sh_nib[i] = 0; live_byte[i] = 0; sh_byte[i] = 0;
      rt_valid[i] = 0; rt_chan[i] = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_pos = 0;
      for (int i = 0; i < 32; i++) begin
        live_nib[i] = 0; sh_nib[i] = 0; live_byte[i] = 0; sh_byte[i] = 0;
        rt_valid[i] = 0; rt_chan[i] = 0;
      end
    end else begin
      if (bit_en && frame_start) begin
        for (int i = 0; i < 32; i++) begin
          sh_nib[i] = live_nib[i];
          sh_byte[i] = live_byte[i];
        end
        m_pos = 0;
      end else if (bit_en) begin
        m_pos = (m_pos + 1) % 256;
      end
      if (nib_we)  live_nib[nib_addr] = nib_data;
      if (byte_we) live_byte[byte_addr] = byte_data;
      if (map_we) begin
        rt_valid[map_addr] = map_data[5];
        rt_chan[map_addr]  = map_data[4:0];
      end
    end
  end

  function automatic void expect_out(output bit eo, output bit ed);
    int ch, b, src;
    ch = m_pos / 8;
    b = 7 - (m_pos % 8);
    eo = 0; ed = 0; src = -1;
    if (!out_en) return;
    case (mode)
      2'b00, 2'b10: begin
        if (b < 4 && (mode == 2'b10 || ch < 24)) begin
          eo = 1; ed = (sh_nib[ch] >> b) & 1;
        end
      end
      2'b01: begin
        for (int t = 31; t >= 0; t--)
          if (rt_valid[t] != 0 && rt_chan[t] < 24 && rt_chan[t] == ch) src = t;
      end
      default: begin
        if (rt_valid[31] != 0 && rt_chan[31] == ch) src = 31;
        if (rt_valid[16] != 0 && rt_chan[16] == ch) src = 16;
        if (rt_valid[15] != 0 && rt_chan[15] == ch) src = 15;
      end
    endcase
    if (src >= 0) begin
      eo = 1; ed = (sh_byte[src] >> b) & 1;
    end
  endfunction

  always @(posedge clk) begin
    bit eo, ed;
    #5;
    if (!done) begin
      expect_out(eo, ed);
      checks++;
      if (ser_oe !== eo || ser_data !== ed) begin
        errors++;
        $display("FAIL %s (%s) pos=%0d mode=%0d: oe/data actual %b/%b expected %b/%b",
                 (!eo && ser_data !== 1'b0) ? "R9" : cur_tag,
                 out_en ? "mode path" : "R7", m_pos, mode, ser_oe, ser_data, eo, ed);
      end
    end
  end

  initial begin
    int n;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      bit_en = gaps ? ((n % 3) != 0) : 1'b1;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_nib(input int a, input int d);
    @(negedge clk);
    nib_we = 1; nib_addr = 5'(a); nib_data = 4'(d);
    @(negedge clk);
    nib_we = 0;
  endtask

  task automatic put_byte(input int a, input int d);
    @(negedge clk);
    byte_we = 1; byte_addr = 5'(a); byte_data = 8'(d);
    @(negedge clk);
    byte_we = 0;
  endtask

  task automatic put_map(input int ts, input int v, input int ch);
    @(negedge clk);
    map_we = 1; map_addr = 5'(ts); map_data = {1'(v), 5'(ch)};
    @(negedge clk);
    map_we = 0;
  endtask

  task automatic new_frame();
    @(negedge clk);
    frame_start = 1;
    @(negedge clk);
    while (!bit_en) @(negedge clk);
    frame_start = 0;
  endtask

  initial begin
    // R10: reset state, buffers clear so nothing but zero data appears
    run(4);
    rst_n = 1;
    run(20);
    for (int i = 0; i < 32; i++) begin
      put_nib(i, (i * 7 + 3) & 15);
      put_byte(i, (i * 37 + 11) & 255);
    end
    cur_tag = "R1";
    new_frame();
    run(300);
    cur_tag = "R2"; mode = 2'b00; run(280);
    cur_tag = "R3"; mode = 2'b10; run(280);
    // R8: write lands on the frame-start edge
    cur_tag = "R8";
    @(negedge clk);
    frame_start = 1; nib_we = 1; nib_addr = 5'd1; nib_data = 4'hA;
    @(negedge clk);
    frame_start = 0; nib_we = 0;
    run(280);
    new_frame();
    run(280);
    cur_tag = "R4"; mode = 2'b01;
    put_map(3, 1, 5); put_map(20, 1, 23); put_map(7, 1, 25); put_map(0, 1, 0);
    new_frame();
    run(300);
    cur_tag = "R6";
    put_map(9, 1, 5); put_map(2, 1, 23); put_map(0, 0, 0);
    run(300);
    cur_tag = "R5"; mode = 2'b11;
    put_map(15, 1, 0); put_map(16, 1, 31); put_map(31, 1, 10); put_map(4, 1, 2);
    run(300);
    put_map(16, 1, 0);
    run(300);
    cur_tag = "R7"; out_en = 0; run(300); out_en = 1;
    cur_tag = "R1"; gaps = 1; mode = 2'b10;
    new_frame();
    put_byte(15, 8'h5C);
    new_frame();
    mode = 2'b11;
    run(900);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule